// File: doc/BRIEF.md
# SONET Receive Frame Aligner and Descrambler

This block takes one byte-wide STS-N lane (STS-12 by default, one byte per 77.76 MHz clock, the rate of a 622 Mbit/s serial lane) and finds where each 125 µs frame begins. It watches the bytes for the boundary between the last A1 framing byte and the first A2 framing byte. It confirms that boundary one frame later and then reports in-frame. While locked it keeps running through frames that have errors. It drops lock only after a run of consecutive errored frames.

A free-running position counter labels every byte with its row and column. The block raises a start-of-frame strobe on row 0, column 0 while in frame. When scrambling is enabled, it removes the frame-synchronous SONET scrambling from all bytes outside the first transport-overhead row. Each lane has its own enable, and dropping it returns the lane to its reset state at once. Every output is registered and appears one clock after the byte that caused it.

Top module: `sfa_frame_aligner`

## Requirements
- R1: While rst_n or chan_en is low, on the following clock edge in_frame, lof, out_valid and out_sof are all 0, the position returns to row 0 column 0 and all lock history is cleared.
- R2: Each output byte appears exactly one clock after its input byte, and out_valid follows in_valid with the same one-clock delay. A clock with in_valid low produces out_valid 0 and does not advance the row/column position.
- R3: The framing mark is a valid byte 0xF6 followed, as the next valid byte, by 0x28. When hunting, the byte 0x28 is taken as row 0, column STS_N, and the next byte is labelled from there.
- R4: in_frame rises only after the mark found while hunting is seen again at the same position in the next frame.
- R5: While in frame, in_frame falls and lof rises after MISS_LIMIT (default 4) consecutive frames have no mark at the expected position. One good frame resets the run, so MISS_LIMIT-1 errored frames followed by a good one keep the lock.
- R6: lof stays high while hunting and clears on the edge where in_frame rises again.
- R7: A frame has ROWS (9) rows of 90*STS_N columns. out_row/out_col give the position of the current byte, and out_sof is 1 only for the row 0, column 0 byte while in frame.
- R8: Bytes in row 0, columns below 3*STS_N, pass through unchanged. Every later byte is XORed with a keystream from x^7+x^6+1. The keystream is seeded to all ones at the first such byte, taken MSB first, and runs across row boundaries. Its first two bytes are 0xFE and 0x04.
- R9: With scr_en low, data passes through unchanged. The keystream position still advances, so re-enabling it needs no resync.
- R10: Once hunting has ended, a mark at any position other than the expected one does not move the row/column count and does not change in_frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Lane enable; low holds the lane in reset |
| scr_en | input | 1 | 1 = descramble payload bytes |
| in_valid | input | 1 | Qualifies in_data |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Qualifies out_data |
| out_data | output | 8 | Byte after optional descrambling |
| out_sof | output | 1 | First byte of a frame while in frame |
| out_row | output | $clog2(ROWS) | Row of the output byte |
| out_col | output | $clog2(90*STS_N) | Column of the output byte |
| in_frame | output | 1 | Lock status |
| lof | output | 1 | Lock was lost after consecutive errored frames |

## Verification
The bench checks that a lane locks on the second good frame and not the first. A design that confirms on one detection would raise in_frame one frame early. It sends three errored frames, then a good one, then four errored frames. A design whose miss count never resets would drop lock on the three-then-good run, and one with the wrong limit would drop lock at the wrong frame. It also injects a false mark in the middle of a locked frame, adds idle clocks inside frames, and streams junk bytes before the first mark. These catch a counter that re-aligns after lock, that counts idle clocks, or that skips the reload when hunting; each of those would misplace out_sof and the row/column labels. Every payload byte is compared with an independent keystream model, so a wrong seed, tap, bit order or overhead boundary shows up in out_data.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam logic [7:0] A1_BYTE  = 8'hF6;
    localparam logic [7:0] A2_BYTE  = 8'h28;
    localparam logic [6:0] SCR_SEED = 7'h7F;

    typedef enum logic [1:0] {
        LK_HUNT    = 2'd0,
        LK_PRESYNC = 2'd1,
        LK_SYNC    = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic [7:0] ks;
        logic [6:0] nxt;
    } scr_step_t;

    // Eight serial steps of x^7 + x^6 + 1; the first bit out is keystream bit 7.
    function automatic scr_step_t scr_step8(input logic [6:0] seed);
        scr_step_t  r;
        logic [6:0] s;
        s    = seed;
        r.ks = '0;
        for (int i = 7; i >= 0; i--) begin
            r.ks[i] = s[6];
            s       = {s[5:0], s[6] ^ s[5]};
        end
        r.nxt = s;
        return r;
    endfunction

endpackage

// File: rtl/sfa_pattern_det.sv
module sfa_pattern_det
    import sfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic [7:0] data,
    output logic       hit
);

    logic [7:0] prev_d, prev_q;

    always_comb begin
        prev_d = prev_q;
        if (clr) begin
            prev_d = '0;
        end else if (adv) begin
            prev_d = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    // Mark: A2 byte whose previous valid byte was the last A1.
    assign hit = adv && !clr && (data == A2_BYTE) && (prev_q == A1_BYTE);

endmodule

// File: rtl/sfa_pos_ctr.sv
module sfa_pos_ctr #(
    parameter  int ROWS     = 9,
    parameter  int COLS     = 1080,
    parameter  int LOAD_COL = 13,
    localparam int RW       = $clog2(ROWS),
    localparam int CW       = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic          load,
    output logic [RW-1:0] row,
    output logic [CW-1:0] col
);

    localparam logic [RW-1:0] LAST_ROW   = RW'(ROWS - 1);
    localparam logic [CW-1:0] LAST_COL   = CW'(COLS - 1);
    localparam logic [CW-1:0] RELOAD_COL = CW'(LOAD_COL);

    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (clr) begin
            pos_d = '0;
        end else if (load) begin
            pos_d.row = '0;
            pos_d.col = RELOAD_COL;
        end else if (adv) begin
            if (pos_q.col == LAST_COL) begin
                pos_d.col = '0;
                pos_d.row = (pos_q.row == LAST_ROW) ? '0 : pos_q.row + 1'b1;
            end else begin
                pos_d.col = pos_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign row = pos_q.row;
    assign col = pos_q.col;

    a_r7_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        row <= LAST_ROW);

    a_r7_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        col <= LAST_COL);

    a_r2_idle_holds_position: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr && !load) |=> ($stable(row) && $stable(col)));

endmodule

// File: rtl/sfa_lock_fsm.sv
module sfa_lock_fsm
    import sfa_pkg::*;
#(
    parameter  int MISS_LIMIT = 4,
    localparam int MW         = $clog2(MISS_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic hit,
    input  logic at_exp,
    output logic load,
    output logic in_frame,
    output logic lof
);

    localparam logic [MW-1:0] MISS_LAST = MW'(MISS_LIMIT - 1);
    localparam logic [MW-1:0] MISS_CAP  = MW'(MISS_LIMIT);

    typedef struct packed {
        lock_state_e   st;
        logic [MW-1:0] miss;
        logic          lof;
    } lk_t;

    localparam lk_t LK_RST = '{st: LK_HUNT, miss: '0, lof: 1'b0};

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        load = 1'b0;
        if (clr) begin
            lk_d = LK_RST;
        end else if (adv) begin
            unique case (lk_q.st)
                LK_HUNT: begin
                    if (hit) begin
                        lk_d.st = LK_PRESYNC;
                        load    = 1'b1;
                    end
                end
                LK_PRESYNC: begin
                    if (at_exp) begin
                        if (hit) begin
                            lk_d.st   = LK_SYNC;
                            lk_d.miss = '0;
                            lk_d.lof  = 1'b0;
                        end else begin
                            lk_d.st = LK_HUNT;
                        end
                    end
                end
                LK_SYNC: begin
                    if (at_exp) begin
                        if (hit) begin
                            lk_d.miss = '0;
                        end else if (lk_q.miss == MISS_LAST) begin
                            lk_d.st   = LK_HUNT;
                            lk_d.miss = '0;
                            lk_d.lof  = 1'b1;
                        end else begin
                            lk_d.miss = lk_q.miss + 1'b1;
                        end
                    end
                end
                default: lk_d = LK_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= LK_RST;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign in_frame = (lk_q.st == LK_SYNC);
    assign lof      = lk_q.lof;

    logic was_presync;
    assign was_presync = (lk_q.st == LK_PRESYNC);

    a_r4_lock_after_confirm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> $past(was_presync));

    a_r5_miss_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        lk_q.miss < MISS_CAP);

    a_r5_lof_only_from_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof) |-> $past(in_frame));

    a_r6_lof_clear_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |-> !lof);

endmodule

// File: rtl/sfa_descrambler.sv
module sfa_descrambler
    import sfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       adv,
    input  logic       skip,
    input  logic       scr_en,
    input  logic [7:0] din,
    output logic [7:0] dout
);

    logic [6:0] lfsr_d, lfsr_q;
    scr_step_t  step;

    always_comb begin
        step   = scr_step8(lfsr_q);
        lfsr_d = lfsr_q;
        if (clr) begin
            lfsr_d = SCR_SEED;
        end else if (adv) begin
            // Overhead bytes of row 0 keep the generator at its seed.
            lfsr_d = skip ? SCR_SEED : step.nxt;
        end
        dout = (scr_en && !skip) ? (din ^ step.ks) : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SCR_SEED;
        end else begin
            lfsr_q <= lfsr_d;
        end
    end

endmodule

// File: rtl/sfa_frame_aligner.sv
module sfa_frame_aligner
    import sfa_pkg::*;
#(
    parameter  int STS_N      = 12,
    parameter  int ROWS       = 9,
    parameter  int MISS_LIMIT = 4,
    localparam int COLS       = 90 * STS_N,
    localparam int RW         = $clog2(ROWS),
    localparam int CW         = $clog2(COLS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          scr_en,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_sof,
    output logic [RW-1:0] out_row,
    output logic [CW-1:0] out_col,
    output logic          in_frame,
    output logic          lof
);

    localparam logic [CW-1:0] MARK_COL = CW'(STS_N);
    localparam logic [CW-1:0] TOH_COLS = CW'(3 * STS_N);

    typedef struct packed {
        logic          valid;
        logic [7:0]    data;
        logic          sof;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } out_t;

    logic          clr;
    logic          hit;
    logic          load;
    logic          at_exp;
    logic          skip;
    logic          locked;
    logic [RW-1:0] cur_row;
    logic [CW-1:0] cur_col;
    logic [7:0]    plain;
    out_t          out_d, out_q;

    assign clr    = !chan_en;
    assign at_exp = (cur_row == '0) && (cur_col == MARK_COL);
    assign skip   = (cur_row == '0) && (cur_col < TOH_COLS);

    sfa_pattern_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (in_valid),
        .data  (in_data),
        .hit   (hit)
    );

    sfa_lock_fsm #(
        .MISS_LIMIT (MISS_LIMIT)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (in_valid),
        .hit      (hit),
        .at_exp   (at_exp),
        .load     (load),
        .in_frame (locked),
        .lof      (lof)
    );

    sfa_pos_ctr #(
        .ROWS     (ROWS),
        .COLS     (COLS),
        .LOAD_COL (STS_N + 1)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .adv   (in_valid),
        .load  (load),
        .row   (cur_row),
        .col   (cur_col)
    );

    sfa_descrambler u_dscr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .adv    (in_valid),
        .skip   (skip),
        .scr_en (scr_en),
        .din    (in_data),
        .dout   (plain)
    );

    always_comb begin
        out_d = out_q;
        if (clr) begin
            out_d = '0;
        end else begin
            out_d.valid = in_valid;
            out_d.sof   = in_valid && locked && (cur_row == '0) && (cur_col == '0);
            if (in_valid) begin
                out_d.data = plain;
                out_d.row  = cur_row;
                out_d.col  = cur_col;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.valid;
    assign out_data  = out_q.data;
    assign out_sof   = out_q.sof;
    assign out_row   = out_q.row;
    assign out_col   = out_q.col;
    assign in_frame  = locked;

    a_r1_disable_forces_oof: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!in_frame && !lof && !out_valid && !out_sof));

    a_r2_valid_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && in_valid) |=> out_valid);

    a_r2_idle_gives_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r7_sof_only_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (in_frame && out_valid));

endmodule

// File: tb/tb_sfa_frame_aligner.sv
module tb_sfa_frame_aligner;

    localparam int STS_N = 1;
    localparam int ROWS  = 9;
    localparam int COLS  = 90 * STS_N;
    localparam int FRAME = ROWS * COLS;
    localparam int TOHC  = 3 * STS_N;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_en = 1'b0;
    logic       scr_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sof;
    logic [3:0] out_row;
    logic [6:0] out_col;
    logic       in_frame;
    logic       lof;

    int n_cmp = 0;
    int n_bad = 0;

    logic [6:0] m_lfsr = 7'h7F;

    // Stimulus table: {good_mark, scr_en, in_frame_after, lof_after}
    localparam int NV = 13;
    localparam logic [3:0] VEC [NV] = '{
        4'b1100, 4'b1110, 4'b1010, 4'b0110, 4'b0110, 4'b0110, 4'b1110,
        4'b0010, 4'b0110, 4'b0110, 4'b0101, 4'b1101, 4'b1110
    };

    sfa_frame_aligner #(.STS_N(STS_N), .ROWS(ROWS), .MISS_LIMIT(4)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .scr_en    (scr_en),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_row   (out_row),
        .out_col   (out_col),
        .in_frame  (in_frame),
        .lof       (lof)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Reference keystream byte from x^7+x^6+1, MSB first.
    function automatic logic [7:0] ref_ks(input logic [6:0] s0);
        logic [6:0] s;
        logic [7:0] k;
        s = s0;
        for (int i = 7; i >= 0; i--) begin
            k[i] = s[6];
            s    = {s[5:0], s[6] ^ s[5]};
        end
        return k;
    endfunction

    function automatic logic [6:0] ref_next(input logic [6:0] s0);
        logic [6:0] s;
        s = s0;
        for (int i = 0; i < 8; i++) s = {s[5:0], s[6] ^ s[5]};
        return s;
    endfunction

    task automatic xfer(input logic v, input logic [7:0] b);
        @(negedge clk);
        in_valid = v;
        in_data  = b;
        @(posedge clk);
        #1;
    endtask

    task automatic send_frame(input logic good, input logic scr, input logic aligned,
                              input logic prev_if, input logic inject, input logic gaps);
        scr_en = scr;
        for (int p = 0; p < FRAME; p++) begin
            int         row;
            int         col;
            logic [7:0] b;
            logic       skip;
            logic [7:0] exp_d;
            row = p / COLS;
            col = p % COLS;
            if (row == 0 && col < STS_N)          b = good ? 8'hF6 : 8'h00;
            else if (row == 0 && col < 2 * STS_N) b = 8'h28;
            else                                  b = p[7:0];
            if (inject && p == 300) b = 8'hF6;
            if (inject && p == 301) b = 8'h28;
            if (gaps && (p % 50) == 25) begin
                xfer(1'b0, 8'hA5);
                check("R2 idle out_valid", int'(out_valid), 0);
            end
            skip  = (row == 0) && (col < TOHC);
            exp_d = (scr && !skip) ? (b ^ ref_ks(m_lfsr)) : b;
            xfer(1'b1, b);
            check("R2 out_valid", int'(out_valid), 1);
            if (aligned) begin
                check("R7 out_row", int'(out_row), row);
                check("R7 out_col", int'(out_col), col);
                check(scr ? "R8 descrambled data" : "R9 passthrough data",
                      int'(out_data), int'(exp_d));
                if (scr && row == 0 && col == TOHC)
                    check("R8 first keystream byte", int'(out_data), int'(b ^ 8'hFE));
                if (scr && row == 0 && col == TOHC + 1)
                    check("R8 second keystream byte", int'(out_data), int'(b ^ 8'h04));
            end
            check("R7 out_sof", int'(out_sof), int'(prev_if && p == 0));
            m_lfsr = skip ? 7'h7F : ref_next(m_lfsr);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        summary();
    end

    initial begin
        logic prev_if;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset in_frame", int'(in_frame), 0);
        check("R1 reset lof", int'(lof), 0);
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset out_sof", int'(out_sof), 0);
        @(negedge clk);
        rst_n   = 1'b1;
        chan_en = 1'b1;

        // Table walk: R3 R4 R5 R6 R7 R8 R9
        prev_if = 1'b0;
        for (int v = 0; v < NV; v++) begin
            logic [3:0] e;
            e = VEC[v];
            send_frame(e[3], e[2], 1'b1, prev_if, 1'b0, 1'b0);
            check($sformatf("R4/R5 in_frame after frame %0d", v), int'(in_frame), int'(e[1]));
            check($sformatf("R5/R6 lof after frame %0d", v), int'(lof), int'(e[0]));
            prev_if = e[1];
        end

        // R10 and R2: false mark mid-frame plus idle clocks while locked
        send_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R10 lock kept after false mark", int'(in_frame), 1);
        send_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R10 lock kept next frame", int'(in_frame), 1);

        // R1: disable mid-lock
        @(negedge clk);
        chan_en  = 1'b0;
        in_valid = 1'b1;
        in_data  = 8'hF6;
        @(posedge clk);
        #1;
        check("R1 disabled in_frame", int'(in_frame), 0);
        check("R1 disabled lof", int'(lof), 0);
        check("R1 disabled out_valid", int'(out_valid), 0);
        @(negedge clk);
        in_valid = 1'b0;
        chan_en  = 1'b1;

        // R3: misalign by junk, then hunting reload realigns
        for (int j = 0; j < 37; j++) xfer(1'b1, 8'h00);
        m_lfsr = 7'h7F;
        send_frame(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4 one detection not enough", int'(in_frame), 0);
        send_frame(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R3/R4 relock after reload", int'(in_frame), 1);
        send_frame(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R7 locked frame after relock", int'(in_frame), 1);

        xfer(1'b0, 8'h00);
        summary();
    end

endmodule